// File: doc/BRIEF.md
# Shared-Bus Ownership Agent

This block stands between one local bus master and a system bus shared by several masters. When its master has work pending, it raises a bus request. It then waits for a priority input, which comes either from an external fixed-priority resolver or from the agent above it in a serial chain. It takes the bus only when that priority input is true and the shared busy line reads free. Once it owns the bus, it drives busy for as long as it holds ownership.

The busy line is active low and wired-OR. The block sees it as a sampled level, `busy_n_in`, and affects it through a registered drive-enable, `busy_drive`. The board or the bench forms the line as the NOR of all agents' drive-enables. An owner that loses priority finishes its current transfer before it lets the line go. An owner that keeps priority may run transfers back to back without releasing the bus.

`prio_out` passes priority to the next agent down a serial chain when this agent is not requesting. The block carries no data, so it has no valid/ready interface. All pins are plain control levels sampled on the rising clock edge, and no back-pressure rules apply.

Top module: `mm_bus_agent`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `bus_req`, `busy_drive` and `granted` are all 0.
- R2: From idle, `bus_req` goes to 1 after the first rising edge at which `xfer_req` is 1. `bus_req` is 1 in every cycle in which `busy_drive` is 1.
- R3: A requesting agent never asserts `busy_drive` at an edge where `busy_n_in` is 0, even if `prio_in` is 1.
- R4: A requesting agent asserts `busy_drive` after the first rising edge at which `xfer_req`, `prio_in` and `busy_n_in` are all 1.
- R5: An owner keeps `busy_drive` at 1 until an edge at which `xfer_done` is 1, whatever `prio_in` does. It also keeps the bus across a transfer boundary (`xfer_done` = 1) when `prio_in` and `xfer_req` are both 1 at that edge.
- R6: An owner drops `busy_drive` after an edge where `xfer_done` is 1 and either `prio_in` or `xfer_req` is 0.
- R7: In the cycle after a release, `bus_req` is still 1. After that it is 0 if `xfer_req` was 0 at the preceding edge, and it stays 1 if a transfer is still pending.
- R8: `prio_out` is 1 exactly when `prio_in` is 1 and `bus_req` is 0.
- R9: `granted` is 1 exactly in the cycles in which the agent drives busy.
- R10: If `xfer_req` falls before ownership is gained, `bus_req` returns to 0 after the next rising edge, and the agent does not take the bus.
- R11: When two agents share one busy line, at most one of them drives busy in any cycle. A higher-priority requester waits until the lower-priority owner releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Local master has a transfer pending |
| xfer_done | input | 1 | Pulse: current transfer ends at this edge |
| prio_in | input | 1 | This agent holds top priority |
| busy_n_in | input | 1 | Sampled level of the shared busy line (0 = taken) |
| bus_req | output | 1 | Registered bus request |
| busy_drive | output | 1 | Registered enable that pulls busy low |
| granted | output | 1 | Agent currently owns the bus |
| prio_out | output | 1 | Priority passed to the next lower agent |

## Verification
The hardest case to reach is a handover. A higher-priority agent must wait on busy while a lower-priority owner finishes a transfer, and the busy line must never be driven by both agents at once. The bench reaches this case with two agents in a serial chain on a modelled wired-OR line. It first lets the lower-priority agent take an idle bus. It then raises the upper agent's request for several cycles before it ends the owner's transfer. The same setup, with the request held, also drives the released owner back into requesting.

// File: rtl/mm_agent_pkg.sv
package mm_agent_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OWN,
    ST_REL
  } agent_state_e;
endpackage

// File: rtl/mm_agent_ctrl.sv
module mm_agent_ctrl
  import mm_agent_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic xfer_done,
  input  logic prio_in,
  input  logic busy_free,
  output logic req_q,
  output logic drive_q
);
  agent_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (xfer_req) state_d = ST_REQ;
      ST_REQ, ST_WAIT: begin
        if (!xfer_req)                  state_d = ST_IDLE;
        else if (prio_in && busy_free)  state_d = ST_OWN;
        else if (prio_in)               state_d = ST_WAIT;
        else                            state_d = ST_REQ;
      end
      ST_OWN: if (xfer_done && !(prio_in && xfer_req)) state_d = ST_REL;
      ST_REL: state_d = xfer_req ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d != ST_IDLE);
      drive_q <= (state_d == ST_OWN);
    end
  end
endmodule

// File: rtl/mm_agent_chain.sv
module mm_agent_chain (
  input  logic prio_in,
  input  logic bus_req,
  output logic prio_out
);
  assign prio_out = prio_in & ~bus_req;
endmodule

// File: rtl/mm_bus_agent.sv
module mm_bus_agent (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic xfer_done,
  input  logic prio_in,
  input  logic busy_n_in,
  output logic bus_req,
  output logic busy_drive,
  output logic granted,
  output logic prio_out
);
  logic req_w, drive_w;

  mm_agent_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_req  (xfer_req),
    .xfer_done (xfer_done),
    .prio_in   (prio_in),
    .busy_free (busy_n_in),
    .req_q     (req_w),
    .drive_q   (drive_w)
  );

  mm_agent_chain u_chain (
    .prio_in  (prio_in),
    .bus_req  (req_w),
    .prio_out (prio_out)
  );

  assign bus_req    = req_w;
  assign busy_drive = drive_w;
  assign granted    = drive_w;
endmodule

// File: rtl/mm_bus_agent_chk.sv
module mm_bus_agent_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_req,
  input logic xfer_done,
  input logic prio_in,
  input logic busy_n_in,
  input logic bus_req,
  input logic busy_drive,
  input logic granted,
  input logic prio_out
);
  // R3 / R4: ownership begins only after an edge with priority and a free line
  assert_take_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_drive) |-> ($past(busy_n_in) && $past(prio_in) && $past(xfer_req)));

  // R2: a driving agent is always requesting
  assert_req_while_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drive |-> bus_req);

  // R5: ownership persists until a transfer boundary
  assert_hold_to_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_drive && !xfer_done) |=> busy_drive);

  // R6: release happens only at a transfer boundary
  assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_drive) |-> $past(xfer_done));

  // R7: request lingers in the cycle after release
  assert_req_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_drive) |-> bus_req);

  // R8: a requesting agent passes no priority downstream
  assert_chain_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !prio_out);

  // R9: grant status tracks busy drive
  assert_grant_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    granted == busy_drive);
endmodule

bind mm_bus_agent mm_bus_agent_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_req   (xfer_req),
  .xfer_done  (xfer_done),
  .prio_in    (prio_in),
  .busy_n_in  (busy_n_in),
  .bus_req    (bus_req),
  .busy_drive (busy_drive),
  .granted    (granted),
  .prio_out   (prio_out)
);

// File: tb/mm_bus_agent_tb.sv
module mm_bus_agent_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] xreq = '0, done = '0;
  logic [1:0] req_o, drv_o, gnt_o, pout_o, pin;
  logic busy_n;

  assign busy_n = ~(drv_o[0] | drv_o[1]);
  assign pin[1] = 1'b1;        // upper agent heads the chain
  assign pin[0] = pout_o[1];   // lower agent fed by chain

  mm_bus_agent u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xreq[0]), .xfer_done(done[0]),
    .prio_in(pin[0]), .busy_n_in(busy_n), .bus_req(req_o[0]),
    .busy_drive(drv_o[0]), .granted(gnt_o[0]), .prio_out(pout_o[0]));

  mm_bus_agent u_peer (
    .clk(clk), .rst_n(rst_n), .xfer_req(xreq[1]), .xfer_done(done[1]),
    .prio_in(pin[1]), .busy_n_in(busy_n), .bus_req(req_o[1]),
    .busy_drive(drv_o[1]), .granted(gnt_o[1]), .prio_out(pout_o[1]));

  int errors = 0, checks = 0, cyc = 0;
  bit m_req[2], m_own[2], m_rel[2];

  // behavioural reference: flags per agent, updated on each edge
  always @(posedge clk) begin
    bit p[2];
    bit freeb;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_req[i] = 0; m_own[i] = 0; m_rel[i] = 0; end
    end else begin
      p[1] = 1; p[0] = !m_req[1];
      freeb = !(m_own[0] || m_own[1]);
      for (int i = 0; i < 2; i++) begin
        if (m_own[i]) begin
          if (done[i] && !(p[i] && xreq[i])) begin m_own[i] = 0; m_rel[i] = 1; end
        end else if (m_rel[i]) begin
          m_rel[i] = 0; m_req[i] = xreq[i];
        end else if (!m_req[i]) begin
          m_req[i] = xreq[i];
        end else if (!xreq[i]) begin
          m_req[i] = 0;
        end else if (p[i] && freeb) begin
          m_own[i] = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      chk(req_o[i] == m_req[i], i ? "R2/R7 peer bus_req" : "R2/R7 dut bus_req", req_o[i], m_req[i]);
      chk(drv_o[i] == m_own[i], i ? "R4/R6 peer busy_drive" : "R4/R6 dut busy_drive", drv_o[i], m_own[i]);
      chk(gnt_o[i] == m_own[i], "R9 granted", gnt_o[i], m_own[i]);
    end
    chk(pout_o[0] == (pin[0] && !m_req[0]), "R8 dut prio_out", pout_o[0], pin[0] && !m_req[0]);
    chk(pout_o[1] == !m_req[1], "R8 peer prio_out", pout_o[1], !m_req[1]);
    chk(!(drv_o[0] && drv_o[1]), "R11 exclusive drive", drv_o, 0);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      compare_all();
    end
  endtask

  task automatic wait_own(input int i);
    for (int k = 0; k < 50 && !m_own[i]; k++) tick();
    chk(m_own[i] == 1, "R4 ownership reached", m_own[i], 1);
  endtask

  task automatic pulse_done(input int i);
    done[i] = 1; tick(); done[i] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_o == 0 && drv_o == 0 && gnt_o == 0, "R1 reset outputs", {req_o, drv_o}, 0);
    rst_n = 1;
    tick();
    chk(req_o == 0 && drv_o == 0, "R1 first cycle after reset", {req_o, drv_o}, 0);

    // lone lower agent takes an idle bus and releases
    xreq[0] = 1; tick();
    chk(req_o[0] == 1, "R2 request raised", req_o[0], 1);
    wait_own(0);
    xreq[0] = 0; pulse_done(0);
    chk(drv_o[0] == 0, "R6 release without pending", drv_o[0], 0);
    chk(req_o[0] == 1, "R7 request held after release", req_o[0], 1);
    tick();
    chk(req_o[0] == 0, "R7 request dropped", req_o[0], 0);

    // upper agent owns; lower must wait on busy
    xreq[1] = 1; wait_own(1);
    xreq[0] = 1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(drv_o[0] == 0, "R3 no take while busy low", drv_o[0], 0);
    end
    xreq[1] = 0; pulse_done(1);
    wait_own(0);

    // lower owns; upper requests: owner finishes first (R11 handover)
    xreq[1] = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(drv_o[0] == 1 && drv_o[1] == 0, "R5/R11 owner kept despite priority loss", drv_o, 1);
    end
    pulse_done(0);
    chk(drv_o[0] == 0, "R6 release after priority loss", drv_o[0], 0);
    tick();
    chk(req_o[0] == 1, "R7 pending request kept", req_o[0], 1);
    wait_own(1);
    xreq[1] = 0; pulse_done(1);
    wait_own(0);

    // back-to-back transfers with priority kept
    pulse_done(0);
    chk(drv_o[0] == 1, "R5 back-to-back keeps bus", drv_o[0], 1);
    tick(2);
    xreq[0] = 0; pulse_done(0);
    chk(drv_o[0] == 0, "R6 release at end", drv_o[0], 0);
    tick(2);

    // withdrawal before ownership
    xreq[1] = 1; wait_own(1);
    xreq[0] = 1; tick(2);
    xreq[0] = 0; tick();
    chk(req_o[0] == 0, "R10 withdraw drops request", req_o[0], 0);
    xreq[1] = 0; pulse_done(1);
    tick(3);
    chk(drv_o[0] == 0, "R10 no later take", drv_o[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule